// File: doc/BRIEF.md
# Fault record ring buffer writer

This block accepts fault records from an address translation unit and stores each one as an eight-word entry in a circular buffer held in memory. It has a single word-write memory port. A software consumer drains the buffer. The block supports several independent rings; by default there are two, one for replayable faults and one for non-replayable faults. Each ring has its own producer index (PUT), consumer index (GET), entry count and enable. The record port selects which ring a record goes to.

Software moves GET forward through a small configuration write port. The block moves PUT forward after it has written the last word of an entry. A ring reports pending work while GET and PUT differ. One slot is always left unused, so that a full ring can be told apart from an empty one. A record that arrives for a full ring is discarded and sets a sticky overflow flag. A GET value outside the ring is refused and sets a sticky bad-pointer flag. Both flags are read back in the GET register and are cleared with write-one bits in that same register.

Top module: `frb_fault_ring`

## Requirements
- R1: After reset, every ring reads PUT=0, GET=0, both flags clear, disabled, with an entry count of MAX_ENT. Both interrupts are low, `rec_ready` is high and `mem_we` is low.
- R2: A record accepted for an enabled ring that is not full produces eight writes on consecutive cycles. The write address is {ring, slot, word} with the word index in the low 3 bits, and the words go out in the order 0 to 7. Words 0 to 6 are copied unchanged. Word 7, the info word, is written last with bit 31 (valid) forced to 1.
- R3: PUT of the target ring advances by one, wrapping to 0 at the entry count, once word 7 has been written. `rec_ready` is low while an entry is being written.
- R4: `notify_irq` of a ring is high exactly while the ring is enabled and GET differs from PUT. It falls once software writes GET equal to PUT.
- R5: A ring is full when GET equals (PUT+1) modulo its entry count. A record that arrives for a full ring causes no memory write and leaves PUT unchanged. It sets the overflow flag (GET register bit 31), which stays set, and `overflow_irq` is high while the flag is set and the ring is enabled.
- R6: A GET write clears the overflow flag when data bit 31 is 1 and the bad-pointer flag when data bit 30 is 1. The same write also loads the pointer from data bits 15:0.
- R7: A GET write whose bits 15:0 are greater than or equal to the entry count leaves GET unchanged and sets the bad-pointer flag (GET register bit 30).
- R8: Writing ENABLE bit 0 = 0 disables a ring. This forces PUT to 0 and holds both interrupts low, while the flags stay readable. Records for a disabled ring are consumed without any write. An entry being written when its ring is disabled stops before its remaining words, so no valid word is written.
- R9: The rings are independent. A record or a configuration write for one ring leaves the PUT, GET, flags and interrupts of every other ring unchanged.
- R10: A SIZE write takes effect only while the ring is disabled and only for values from 2 to MAX_ENT, and it also sets GET to 0. Any other SIZE write is ignored. Configuration select codes: 0 = GET, 1 = SIZE, 2 = ENABLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_valid | input | 1 | A fault record is offered |
| rec_ring | input | RING_W | Target ring of the record |
| rec_words | input | 256 | Record words 0..7; word k sits in bits 32k+31:32k |
| rec_ready | output | 1 | Writer idle; the record is taken on this edge |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ring | input | RING_W | Ring addressed by the configuration write |
| cfg_sel | input | 2 | 0 = GET, 1 = SIZE, 2 = ENABLE |
| cfg_wdata | input | 32 | Configuration write data |
| mem_we | output | 1 | Memory word write enable |
| mem_addr | output | ADDR_W | Word address {ring, slot, word} |
| mem_wdata | output | 32 | Memory write data |
| get_reg | output | NUM_RING*32 | Per-ring GET read-back: bit 31 overflow, bit 30 bad pointer, low bits the index |
| put_idx | output | NUM_RING*IDX_W | Per-ring PUT index |
| notify_irq | output | NUM_RING | Per-ring pending-entries interrupt |
| overflow_irq | output | NUM_RING | Per-ring overflow interrupt |

## Verification
The bench uses the default parameters: two rings and MAX_ENT=8, which gives a 7-bit word address. At run time it sets ring 0 to 4 and later 6 entries, and leaves ring 1 at 8. With ring 0 at 4 entries, only three records fill it, which reaches the full case, the overflow drop and the wrap of PUT to zero. Refused and accepted GET writes near the entry count then show whether an ignored SIZE write changed the count, and the second ring shows the ring bit in the address and that the rings are independent.

// File: rtl/frb_pkg.sv
package frb_pkg;
    localparam int unsigned ENTRY_WORDS = 8;
    localparam int unsigned WORD_SEL_W  = 3;
    localparam int unsigned REC_W       = ENTRY_WORDS * 32;
    localparam int unsigned VALID_BIT   = 31;
    localparam int unsigned OVF_BIT     = 31;
    localparam int unsigned BADPTR_BIT  = 30;
    localparam int unsigned PTR_FIELD_W = 16;

    typedef enum logic [1:0] {
        CFG_GET    = 2'd0,
        CFG_SIZE   = 2'd1,
        CFG_ENABLE = 2'd2,
        CFG_NONE   = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_BUSY = 1'b1
    } wr_state_e;
endpackage

// File: rtl/frb_ring_ctrl.sv
module frb_ring_ctrl
    import frb_pkg::*;
#(
    parameter int unsigned MAX_ENT = 8,
    parameter int unsigned IDX_W   = 3,
    parameter int unsigned CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             put_step,
    input  logic             ovf_hit,
    output logic             en_o,
    output logic             full_o,
    output logic [IDX_W-1:0] put_o,
    output logic [31:0]      get_reg_o,
    output logic             notify_o,
    output logic             ovf_irq_o
);
    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] get;
        logic [IDX_W-1:0] put;
        logic [CNT_W-1:0] size;
        logic             ovf;
        logic             bad_get;
    } ring_st_t;

    ring_st_t st_d, st_q;

    logic [CNT_W-1:0]       put_inc;
    logic [IDX_W-1:0]       put_next;
    logic [PTR_FIELD_W-1:0] wr_ptr;
    logic                   unused_cfg_bits;

    assign put_inc  = {1'b0, st_q.put} + CNT_W'(1);
    assign put_next = (put_inc == st_q.size) ? '0 : put_inc[IDX_W-1:0];
    assign wr_ptr   = cfg_wdata[PTR_FIELD_W-1:0];
    assign unused_cfg_bits = ^cfg_wdata[29:PTR_FIELD_W];

    always_comb begin
        st_d = st_q;
        if (put_step && st_q.en) begin
            st_d.put = put_next;
        end
        if (cfg_we) begin
            case (cfg_sel)
                CFG_GET: begin
                    if (cfg_wdata[OVF_BIT]) begin
                        st_d.ovf = 1'b0;
                    end
                    if (cfg_wdata[BADPTR_BIT]) begin
                        st_d.bad_get = 1'b0;
                    end
                    if (wr_ptr < PTR_FIELD_W'(st_q.size)) begin
                        st_d.get = wr_ptr[IDX_W-1:0];
                    end else begin
                        st_d.bad_get = 1'b1;
                    end
                end
                CFG_SIZE: begin
                    if (!st_q.en && wr_ptr >= PTR_FIELD_W'(2)
                        && wr_ptr <= PTR_FIELD_W'(MAX_ENT)) begin
                        st_d.size = wr_ptr[CNT_W-1:0];
                        st_d.get  = '0;
                    end
                end
                CFG_ENABLE: begin
                    st_d.en = cfg_wdata[0];
                end
                default: begin
                end
            endcase
        end
        if (ovf_hit && st_q.en) begin
            st_d.ovf = 1'b1;
        end
        if (!st_d.en) begin
            st_d.put = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en      <= 1'b0;
            st_q.get     <= '0;
            st_q.put     <= '0;
            st_q.size    <= CNT_W'(MAX_ENT);
            st_q.ovf     <= 1'b0;
            st_q.bad_get <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        get_reg_o              = '0;
        get_reg_o[IDX_W-1:0]   = st_q.get;
        get_reg_o[BADPTR_BIT]  = st_q.bad_get;
        get_reg_o[OVF_BIT]     = st_q.ovf;
    end

    assign en_o      = st_q.en;
    assign full_o    = (st_q.get == put_next);
    assign put_o     = st_q.put;
    assign notify_o  = st_q.en && (st_q.get != st_q.put);
    assign ovf_irq_o = st_q.en && st_q.ovf;

    // R3: PUT always stays inside the configured ring
    assert_put_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, st_q.put} < st_q.size));

    // R3: a completed entry on an enabled ring moves PUT
    assert_put_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (put_step && st_q.en && !(cfg_we && cfg_sel == CFG_ENABLE))
        |=> !$stable(st_q.put));

    // R8: a disabled ring holds PUT at zero
    assert_disabled_put_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en) |-> (st_q.put == '0));

    // R7: an out-of-range GET write leaves GET alone and raises the flag
    assert_bad_get_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == CFG_GET && wr_ptr >= PTR_FIELD_W'(st_q.size))
        |=> (st_q.bad_get && $stable(st_q.get)));
endmodule

// File: rtl/frb_entry_writer.sv
module frb_entry_writer
    import frb_pkg::*;
#(
    parameter int unsigned NUM_RING = 2,
    parameter int unsigned RING_W   = 1,
    parameter int unsigned IDX_W    = 3,
    parameter int unsigned ADDR_W   = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rec_valid,
    input  logic [RING_W-1:0]         rec_ring,
    input  logic [REC_W-1:0]          rec_words,
    output logic                      rec_ready,
    input  logic [NUM_RING-1:0]       ring_en,
    input  logic [NUM_RING-1:0]       ring_full,
    input  logic [NUM_RING*IDX_W-1:0] ring_put,
    output logic [NUM_RING-1:0]       put_step,
    output logic [NUM_RING-1:0]       ovf_hit,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [31:0]               mem_wdata
);
    typedef struct packed {
        wr_state_e             state;
        logic [RING_W-1:0]     ring;
        logic [IDX_W-1:0]      slot;
        logic [WORD_SEL_W-1:0] cnt;
        logic [REC_W-1:0]      words;
    } wr_st_t;

    wr_st_t wr_d, wr_q;

    logic        sel_ok;
    logic        cur_en;
    logic [31:0] raw_word;

    assign sel_ok = ({1'b0, rec_ring} < (RING_W+1)'(NUM_RING));
    assign cur_en = ring_en[wr_q.ring];

    always_comb begin
        wr_d     = wr_q;
        put_step = '0;
        ovf_hit  = '0;
        case (wr_q.state)
            WR_IDLE: begin
                if (rec_valid && sel_ok && ring_en[rec_ring]) begin
                    if (ring_full[rec_ring]) begin
                        ovf_hit[rec_ring] = 1'b1;
                    end else begin
                        wr_d.state = WR_BUSY;
                        wr_d.ring  = rec_ring;
                        wr_d.slot  = ring_put[rec_ring*IDX_W +: IDX_W];
                        wr_d.cnt   = '0;
                        wr_d.words = rec_words;
                    end
                end
            end
            default: begin
                if (!cur_en) begin
                    wr_d.state = WR_IDLE;
                end else if (wr_q.cnt == WORD_SEL_W'(ENTRY_WORDS - 1)) begin
                    wr_d.state = WR_IDLE;
                    put_step[wr_q.ring] = 1'b1;
                end else begin
                    wr_d.cnt = wr_q.cnt + WORD_SEL_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q.state <= WR_IDLE;
            wr_q.ring  <= '0;
            wr_q.slot  <= '0;
            wr_q.cnt   <= '0;
            wr_q.words <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign raw_word  = wr_q.words[wr_q.cnt*32 +: 32];
    assign rec_ready = (wr_q.state == WR_IDLE);
    assign mem_we    = (wr_q.state == WR_BUSY) && cur_en;
    assign mem_addr  = {wr_q.ring, wr_q.slot, wr_q.cnt};

    always_comb begin
        mem_wdata = raw_word;
        if (wr_q.cnt == WORD_SEL_W'(ENTRY_WORDS - 1)) begin
            mem_wdata[VALID_BIT] = 1'b1;
        end
    end

    // R2: words of an entry go out in ascending order, the info word last
    assert_word_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr[2:0] != 3'd7)
        |=> (!mem_we || mem_addr[2:0] == $past(mem_addr[2:0]) + 3'd1));

    // R5: a record meeting a full ring starts no write
    assert_no_overflow_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_ready && sel_ok && ring_en[rec_ring] && ring_full[rec_ring])
        |=> !mem_we);

    // R3: no new record is taken while an entry is in flight
    assert_busy_not_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rec_ready);

    // R8: the write stops the cycle after its ring is disabled
    assert_abort_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q.state == WR_BUSY && !cur_en) |=> !mem_we);
endmodule

// File: rtl/frb_fault_ring.sv
module frb_fault_ring
    import frb_pkg::*;
#(
    parameter int unsigned NUM_RING = 2,
    parameter int unsigned MAX_ENT  = 8,
    localparam int unsigned IDX_W   = $clog2(MAX_ENT),
    localparam int unsigned CNT_W   = IDX_W + 1,
    localparam int unsigned RING_W  = (NUM_RING > 1) ? $clog2(NUM_RING) : 1,
    localparam int unsigned ADDR_W  = RING_W + IDX_W + WORD_SEL_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rec_valid,
    input  logic [RING_W-1:0]         rec_ring,
    input  logic [REC_W-1:0]          rec_words,
    output logic                      rec_ready,
    input  logic                      cfg_we,
    input  logic [RING_W-1:0]         cfg_ring,
    input  logic [1:0]                cfg_sel,
    input  logic [31:0]               cfg_wdata,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [31:0]               mem_wdata,
    output logic [NUM_RING*32-1:0]    get_reg,
    output logic [NUM_RING*IDX_W-1:0] put_idx,
    output logic [NUM_RING-1:0]       notify_irq,
    output logic [NUM_RING-1:0]       overflow_irq
);
    logic [NUM_RING-1:0] ring_en;
    logic [NUM_RING-1:0] ring_full;
    logic [NUM_RING-1:0] put_step;
    logic [NUM_RING-1:0] ovf_hit;

    for (genvar r = 0; r < NUM_RING; r++) begin : g_ring
        frb_ring_ctrl #(
            .MAX_ENT (MAX_ENT),
            .IDX_W   (IDX_W),
            .CNT_W   (CNT_W)
        ) u_ring (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we && (cfg_ring == RING_W'(r))),
            .cfg_sel   (cfg_sel),
            .cfg_wdata (cfg_wdata),
            .put_step  (put_step[r]),
            .ovf_hit   (ovf_hit[r]),
            .en_o      (ring_en[r]),
            .full_o    (ring_full[r]),
            .put_o     (put_idx[r*IDX_W +: IDX_W]),
            .get_reg_o (get_reg[r*32 +: 32]),
            .notify_o  (notify_irq[r]),
            .ovf_irq_o (overflow_irq[r])
        );
    end

    frb_entry_writer #(
        .NUM_RING (NUM_RING),
        .RING_W   (RING_W),
        .IDX_W    (IDX_W),
        .ADDR_W   (ADDR_W)
    ) u_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_valid (rec_valid),
        .rec_ring  (rec_ring),
        .rec_words (rec_words),
        .rec_ready (rec_ready),
        .ring_en   (ring_en),
        .ring_full (ring_full),
        .ring_put  (put_idx),
        .put_step  (put_step),
        .ovf_hit   (ovf_hit),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );
endmodule

// File: tb/sim_frb_fault_ring.sv
module sim_frb_fault_ring;
    localparam int NR = 2;
    localparam int ME = 8;
    localparam int IW = 3;
    localparam int AW = 7;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n;
    logic            rec_valid;
    logic [0:0]      rec_ring;
    logic [255:0]    rec_words;
    logic            rec_ready;
    logic            cfg_we;
    logic [0:0]      cfg_ring;
    logic [1:0]      cfg_sel;
    logic [31:0]     cfg_wdata;
    logic            mem_we;
    logic [AW-1:0]   mem_addr;
    logic [31:0]     mem_wdata;
    logic [NR*32-1:0] get_reg;
    logic [NR*IW-1:0] put_idx;
    logic [NR-1:0]   notify_irq;
    logic [NR-1:0]   overflow_irq;

    frb_fault_ring #(.NUM_RING(NR), .MAX_ENT(ME)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rec_valid(rec_valid), .rec_ring(rec_ring), .rec_words(rec_words),
        .rec_ready(rec_ready),
        .cfg_we(cfg_we), .cfg_ring(cfg_ring), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .get_reg(get_reg), .put_idx(put_idx),
        .notify_irq(notify_irq), .overflow_irq(overflow_irq)
    );

    int total = 0;
    int bad = 0;
    logic [AW+31:0] exp_q[$];

    int m_get[NR];
    int m_put[NR];
    int m_size[NR];
    bit m_en[NR];
    bit m_ovf[NR];
    bit m_bad[NR];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int seed, input int w);
        return {1'b0, 7'(seed), 8'h5A, 8'(w), 8'(seed * 3 + w)};
    endfunction

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // monitor: every memory write is compared with the scoreboard head
    always @(negedge clk) begin
        if (rst_n === 1'b1 && mem_we === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected memory write", {25'd0, mem_addr, mem_wdata}, 64'd0);
            end else begin
                logic [AW+31:0] e;
                e = exp_q.pop_front();
                check({mem_addr, mem_wdata} == e, "R2", "memory write addr/data",
                      {25'd0, mem_addr, mem_wdata}, {25'd0, e});
            end
        end
    end

    task automatic check_ring(input int r, input string req);
        logic [31:0] eg;
        eg = 32'(m_get[r]);
        eg[31] = m_ovf[r];
        eg[30] = m_bad[r];
        check(put_idx[r*IW +: IW] == IW'(m_put[r]), req, $sformatf("ring%0d put", r),
              64'(put_idx[r*IW +: IW]), 64'(m_put[r]));
        check(get_reg[r*32 +: 32] == eg, req, $sformatf("ring%0d get reg", r),
              64'(get_reg[r*32 +: 32]), 64'(eg));
        check(notify_irq[r] == (m_en[r] && m_get[r] != m_put[r]), req,
              $sformatf("ring%0d notify", r), 64'(notify_irq[r]),
              64'(m_en[r] && m_get[r] != m_put[r]));
        check(overflow_irq[r] == (m_en[r] && m_ovf[r]), req,
              $sformatf("ring%0d overflow irq", r), 64'(overflow_irq[r]),
              64'(m_en[r] && m_ovf[r]));
    endtask

    // select codes: 0 GET, 1 SIZE, 2 ENABLE (R10)
    task automatic cfg_write(input int r, input int sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_ring = 1'(r);
        cfg_sel = 2'(sel);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 0) begin
            if (data[31]) m_ovf[r] = 1'b0;
            if (data[30]) m_bad[r] = 1'b0;
            if (int'(data[15:0]) < m_size[r]) m_get[r] = int'(data[15:0]);
            else m_bad[r] = 1'b1;
        end else if (sel == 1) begin
            if (!m_en[r] && int'(data[15:0]) >= 2 && int'(data[15:0]) <= ME) begin
                m_size[r] = int'(data[15:0]);
                m_get[r] = 0;
            end
        end else if (sel == 2) begin
            m_en[r] = data[0];
            if (!m_en[r]) m_put[r] = 0;
        end
    endtask

    task automatic offer(input int r, input int seed, input int nwords);
        @(negedge clk);
        while (!rec_ready) @(negedge clk);
        rec_valid = 1'b1;
        rec_ring = 1'(r);
        for (int w = 0; w < 8; w++) rec_words[w*32 +: 32] = word_of(seed, w);
        if (m_en[r]) begin
            if (m_get[r] == (m_put[r] + 1) % m_size[r]) begin
                m_ovf[r] = 1'b1;
            end else begin
                for (int w = 0; w < nwords; w++) begin
                    logic [31:0] d;
                    d = word_of(seed, w);
                    if (w == 7) d[31] = 1'b1;
                    exp_q.push_back({1'(r), IW'(m_put[r]), 3'(w), d});
                end
                if (nwords == 8) m_put[r] = (m_put[r] + 1) % m_size[r];
            end
        end
        @(negedge clk);
        rec_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!rec_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send(input int r, input int seed);
        offer(r, seed, 8);
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        rec_valid = 1'b0;
        rec_ring = '0;
        rec_words = '0;
        cfg_we = 1'b0;
        cfg_ring = '0;
        cfg_sel = 2'd3;
        cfg_wdata = '0;
        for (int r = 0; r < NR; r++) begin
            m_get[r] = 0; m_put[r] = 0; m_size[r] = ME;
            m_en[r] = 1'b0; m_ovf[r] = 1'b0; m_bad[r] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(rec_ready == 1'b1, "R1", "rec_ready after reset", 64'(rec_ready), 64'd1);
        check(mem_we == 1'b0, "R1", "mem_we after reset", 64'(mem_we), 64'd0);
        check_ring(0, "R1");
        check_ring(1, "R1");

        // R8 record to a disabled ring is dropped
        send(0, 1);
        check_ring(0, "R8");

        // R2/R3/R4 first entry on ring 0 (size 4), ring 1 untouched (R9)
        cfg_write(0, 1, 32'd4);
        cfg_write(0, 2, 32'd1);
        send(0, 2);
        check_ring(0, "R3");
        check_ring(1, "R9");

        // R5 fill to full then overflow
        send(0, 3);
        send(0, 4);
        send(0, 5);
        check_ring(0, "R5");

        // R6 GET update and overflow clear in one write; R4 notify falls
        cfg_write(0, 0, 32'h8000_0003);
        check_ring(0, "R6");

        // R7 out-of-range GET is refused
        cfg_write(0, 0, 32'd5);
        check_ring(0, "R7");
        cfg_write(0, 0, 32'h4000_0003);
        check_ring(0, "R6");

        // R3 PUT wraps from 3 to 0
        send(0, 6);
        check_ring(0, "R3");

        // R9 ring 1 entry carries ring bit in address
        cfg_write(1, 2, 32'd1);
        send(1, 7);
        check_ring(1, "R9");
        check_ring(0, "R9");

        // R10 size write while enabled is ignored: GET 5 still accepted
        cfg_write(1, 1, 32'd2);
        cfg_write(1, 0, 32'd5);
        check_ring(1, "R10");

        // R5 second overflow on ring 0
        send(0, 8);
        send(0, 9);
        send(0, 10);
        check_ring(0, "R5");

        // R8 disable: PUT to zero, irqs low, flag kept
        cfg_write(0, 2, 32'd0);
        check_ring(0, "R8");

        // R10 out-of-range sizes ignored, then a valid size accepted
        cfg_write(0, 1, 32'd9);
        cfg_write(0, 1, 32'd1);
        cfg_write(0, 0, 32'd4);
        check_ring(0, "R10");
        cfg_write(0, 1, 32'd6);
        cfg_write(0, 0, 32'd5);
        check_ring(0, "R10");
        cfg_write(0, 0, 32'hC000_0000);
        check_ring(0, "R6");

        // R8 disable during an entry: only words 0 and 1 reach memory
        cfg_write(0, 2, 32'd1);
        offer(0, 11, 2);
        cfg_write(0, 2, 32'd0);
        wait_idle();
        check_ring(0, "R8");
        check(rec_ready == 1'b1, "R8", "rec_ready after abort", 64'(rec_ready), 64'd1);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2", "scoreboard drained", 64'(exp_q.size()), 64'd0);
        finish_run();
    end
endmodule